// File: doc/BRIEF.md
# Auto-Increment Word Programmer with Erased-Word Skip

This block writes a buffer of bytes into a serial NOR flash by way of the flash's auto-address-increment word-program command. It drives an SPI byte port one frame at a time, with a select line and a byte request/acknowledge handshake. It reads the source data as 16-bit words through an asynchronous buffer read port, where the low byte of each word is the byte at the lower address. The serial shifter, erase and read traffic are handled elsewhere.

Words whose two bytes both hold the erased value (0xFF) are not programmed: the target address steps over them. The remaining words are grouped into runs of consecutive programmable words. Each run begins with a status poll and a write-enable frame. Its first word frame carries the target address, later word frames carry data only, and the run closes with a write-disable frame. After every word the flash status is polled until the busy bit clears. That final status is then judged, and any mismatch latches an error output while the transfer carries on to the end.

Top module: `aai_word_programmer`

## Requirements
- R1: A transfer covers ceil(byte_cnt_i / 2) words. Word i is read at buffer index i; bits [7:0] belong to address base+2i and are sent first, and bits [15:8] are sent second. For an odd count the upper byte of the last word is sent as the buffer holds it. A count of 0 ends with done_o and no frame.
- R2: A word equal to 0xFFFF is never programmed; the address advances by 2 past it. A buffer made only of such words produces no frame at all.
- R3: Before each run the engine issues status-poll frames (0x05 then 0x00; the status byte is the one received with the second byte) until status bit 0 (busy) reads 0. Only then does it send the single-byte write-enable frame 0x06.
- R4: The first word of a run goes out as one 6-byte frame: 0xAD, address bits [23:16], [15:8], [7:0], then the low data byte and the high data byte.
- R5: Each later word of the same run goes out as one 3-byte frame: 0xAD, the low data byte, the high data byte.
- R6: After every word frame, status-poll frames repeat until bit 0 reads 0, and no other frame is sent while the flash reports busy.
- R7: A run ends when the words are used up or the next word is 0xFFFF. The single-byte frame 0x04 is then sent, and a later run begins again with R3 and R4 at its own address.
- R8: The not-busy status that follows a word must have bit 1 and bit 6 set and bits 5..2 clear. Otherwise err_o is set, stays set until the next accepted start, and the transfer still completes every frame.
- R9: spi_req_o is high only inside a frame (spi_sel_o high). spi_tx_o holds until spi_ack_i, and spi_sel_o stays low for at least one cycle between frames.
- R10: busy_o is high from the cycle after an accepted start until done_o. done_o is a single-cycle pulse, and no frame is open while busy_o is low.
- R11: After reset spi_sel_o, spi_req_o, busy_o, done_o and err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a transfer (taken while idle) |
| base_addr_i | input | ADDR_W | Flash byte address of buffer byte 0 |
| byte_cnt_i | input | CNT_W | Number of bytes to program |
| buf_idx_o | output | CNT_W | Word index into the source buffer |
| buf_word_i | input | 16 | Source word at buf_idx_o (same cycle) |
| spi_sel_o | output | 1 | Flash select, high for the length of a frame |
| spi_req_o | output | 1 | A byte is offered on spi_tx_o |
| spi_tx_o | output | 8 | Byte to shift out |
| spi_ack_i | input | 1 | Shifter finished the current byte |
| spi_rx_i | input | 8 | Byte received with that shift, valid with spi_ack_i |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| err_o | output | 1 | Latched status-check failure |

## Verification
Two events can fall on the same word boundary: a run ending and the erased-word skip starting. This happens when the word after a programmed word is 0xFFFF, and most sharply when that erased word is also the last word of the buffer, so that the exhaustion and erased-word exits coincide. Buffers with erased words in the middle, at the start and at the final position provoke this. The bench judges it by comparing the full non-poll frame log against a list built from the requirements: exactly one 0x04 frame per run, and no stray word or address frame after it. A flash model that holds busy across several polls, including one run that starts with the flash busy, catches any command frame sent while busy.

// File: rtl/aai_prog_pkg.sv
package aai_prog_pkg;

   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_WRDI = 8'h04;
   localparam logic [7:0] OP_RDSR = 8'h05;
   localparam logic [7:0] OP_AAI  = 8'hAD;

   localparam int ST_BUSY  = 0;
   localparam int ST_WEL   = 1;
   localparam int ST_BP_LO = 2;
   localparam int ST_BP_HI = 5;
   localparam int ST_AAI   = 6;

   localparam int ADDR_BYTES = 3;
   localparam int MAX_FRAME  = 6;

   typedef enum logic [2:0] {
      FK_WREN,
      FK_WRDI,
      FK_POLL,
      FK_AAI_FIRST,
      FK_AAI_NEXT
   } frame_kind_e;

   function automatic logic [2:0] frame_len(frame_kind_e k);
      unique case (k)
         FK_WREN:      return 3'd1;
         FK_WRDI:      return 3'd1;
         FK_POLL:      return 3'd2;
         FK_AAI_FIRST: return 3'd6;
         FK_AAI_NEXT:  return 3'd3;
         default:      return 3'd1;
      endcase
   endfunction

endpackage

// File: rtl/aai_word_cursor.sv
module aai_word_cursor #(
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CNT_W-1:0]  bytes_i,
   input  logic              step_i,
   output logic [CNT_W-1:0]  idx_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              have_o
);
   localparam int WIDE_W = CNT_W + 1;

   logic [WIDE_W-1:0] words_w;
   logic [CNT_W-1:0]  left_q;

   assign words_w = (WIDE_W'(bytes_i) + WIDE_W'(1)) >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_o  <= '0;
         addr_o <= '0;
         left_q <= '0;
      end else if (load_i) begin
         idx_o  <= '0;
         addr_o <= base_i;
         left_q <= words_w[CNT_W-1:0];
      end else if (step_i && (left_q != '0)) begin
         idx_o  <= idx_o + CNT_W'(1);
         addr_o <= addr_o + ADDR_W'(2);
         left_q <= left_q - CNT_W'(1);
      end
   end

   assign have_o = (left_q != '0);

endmodule

// File: rtl/aai_status_judge.sv
module aai_status_judge
   import aai_prog_pkg::*;
(
   input  logic [7:0] status_i,
   output logic       busy_o,
   output logic       ok_o
);
   logic bp_clear;

   assign busy_o   = status_i[ST_BUSY];
   assign bp_clear = (status_i[ST_BP_HI:ST_BP_LO] == '0);
   assign ok_o     = status_i[ST_WEL] & status_i[ST_AAI] & bp_clear;

endmodule

// File: rtl/aai_frame_unit.sv
module aai_frame_unit
   import aai_prog_pkg::*;
#(
   parameter int         ADDR_W     = 24,
   parameter logic [7:0] DUMMY_BYTE = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  frame_kind_e       kind_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [15:0]       word_i,
   output logic              sel_o,
   output logic              req_o,
   output logic [7:0]        tx_o,
   input  logic              ack_i,
   input  logic [7:0]        rx_i,
   output logic              fin_o,
   output logic [7:0]        rx_last_o
);
   localparam int FULL_W = 8 * ADDR_BYTES;

   typedef enum logic [1:0] {FU_IDLE, FU_SHIFT, FU_GAP} fu_state_e;

   fu_state_e         st_q;
   frame_kind_e       kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [15:0]       word_q;
   logic [2:0]        pos_q;
   logic [2:0]        len_q;
   logic [FULL_W-1:0] addr_full;
   logic [7:0]        abyte [ADDR_BYTES];
   logic [7:0]        seq   [MAX_FRAME];

   if (ADDR_W < FULL_W) begin : g_addr_pad
      assign addr_full = {{(FULL_W-ADDR_W){1'b0}}, addr_q};
   end else begin : g_addr_full
      assign addr_full = addr_q;
   end

   for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_abyte
      assign abyte[b] = addr_full[8*(ADDR_BYTES-1-b) +: 8];
   end

   always_comb begin
      for (int k = 0; k < MAX_FRAME; k++) seq[k] = 8'h00;
      unique case (kind_q)
         FK_WREN: seq[0] = OP_WREN;
         FK_WRDI: seq[0] = OP_WRDI;
         FK_POLL: begin
            seq[0] = OP_RDSR;
            seq[1] = DUMMY_BYTE;
         end
         FK_AAI_FIRST: begin
            seq[0] = OP_AAI;
            for (int k = 0; k < ADDR_BYTES; k++) seq[1+k] = abyte[k];
            seq[1+ADDR_BYTES] = word_q[7:0];
            seq[2+ADDR_BYTES] = word_q[15:8];
         end
         FK_AAI_NEXT: begin
            seq[0] = OP_AAI;
            seq[1] = word_q[7:0];
            seq[2] = word_q[15:8];
         end
         default: seq[0] = OP_WRDI;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= FU_IDLE;
         kind_q    <= FK_WRDI;
         addr_q    <= '0;
         word_q    <= '0;
         pos_q     <= '0;
         len_q     <= '0;
         rx_last_o <= '0;
      end else begin
         unique case (st_q)
            FU_IDLE: if (go_i) begin
               st_q   <= FU_SHIFT;
               kind_q <= kind_i;
               addr_q <= addr_i;
               word_q <= word_i;
               pos_q  <= '0;
               len_q  <= frame_len(kind_i);
            end
            FU_SHIFT: if (ack_i) begin
               rx_last_o <= rx_i;
               if (pos_q == len_q - 3'd1) st_q <= FU_GAP;
               else pos_q <= pos_q + 3'd1;
            end
            FU_GAP:  st_q <= FU_IDLE;
            default: st_q <= FU_IDLE;
         endcase
      end
   end

   assign sel_o = (st_q == FU_SHIFT);
   assign req_o = (st_q == FU_SHIFT);
   assign tx_o  = seq[pos_q];
   assign fin_o = (st_q == FU_GAP);

endmodule

// File: rtl/aai_word_programmer.sv
module aai_word_programmer
   import aai_prog_pkg::*;
#(
   parameter int         ADDR_W      = 24,
   parameter int         CNT_W       = 16,
   parameter logic [7:0] DUMMY_BYTE  = 8'h00,
   parameter logic [7:0] ERASED_BYTE = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [CNT_W-1:0]  byte_cnt_i,
   output logic [CNT_W-1:0]  buf_idx_o,
   input  logic [15:0]       buf_word_i,
   output logic              spi_sel_o,
   output logic              spi_req_o,
   output logic [7:0]        spi_tx_o,
   input  logic              spi_ack_i,
   input  logic [7:0]        spi_rx_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o
);
   localparam logic [15:0] ERASED_WORD = {2{ERASED_BYTE}};

   if (ADDR_W < 2 || ADDR_W > 8 * ADDR_BYTES) begin : g_bad_addr_w
      $error("aai_word_programmer: ADDR_W must lie in 2..24");
   end
   if (CNT_W < 2 || CNT_W > 31) begin : g_bad_cnt_w
      $error("aai_word_programmer: CNT_W must lie in 2..31");
   end

   typedef enum logic [3:0] {
      S_IDLE, S_SKIP, S_POLL_GO, S_POLL_WAIT, S_WREN_GO, S_WREN_WAIT,
      S_WORD_GO, S_WORD_WAIT, S_ADV, S_EVAL, S_WRDI_GO, S_WRDI_WAIT, S_FIN
   } ctl_state_e;

   ctl_state_e        st_q;
   logic              first_q;
   logic              after_word_q;
   logic              cur_load;
   logic              cur_step;
   logic              cur_have;
   logic [ADDR_W-1:0] cur_addr;
   logic              word_erased;
   logic              fu_go;
   frame_kind_e       fu_kind;
   logic              fu_fin;
   logic [7:0]        fu_rx;
   logic              st_busy;
   logic              st_ok;

   assign word_erased = (buf_word_i == ERASED_WORD);

   aai_word_cursor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cursor (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (cur_load),
      .base_i  (base_addr_i),
      .bytes_i (byte_cnt_i),
      .step_i  (cur_step),
      .idx_o   (buf_idx_o),
      .addr_o  (cur_addr),
      .have_o  (cur_have)
   );

   aai_frame_unit #(.ADDR_W(ADDR_W), .DUMMY_BYTE(DUMMY_BYTE)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_i      (fu_go),
      .kind_i    (fu_kind),
      .addr_i    (cur_addr),
      .word_i    (buf_word_i),
      .sel_o     (spi_sel_o),
      .req_o     (spi_req_o),
      .tx_o      (spi_tx_o),
      .ack_i     (spi_ack_i),
      .rx_i      (spi_rx_i),
      .fin_o     (fu_fin),
      .rx_last_o (fu_rx)
   );

   aai_status_judge u_judge (
      .status_i (fu_rx),
      .busy_o   (st_busy),
      .ok_o     (st_ok)
   );

   always_comb begin
      cur_load = (st_q == S_IDLE) && start_i;
      cur_step = ((st_q == S_SKIP) && cur_have && word_erased) || (st_q == S_ADV);
      fu_go    = 1'b0;
      fu_kind  = FK_POLL;
      unique case (st_q)
         S_POLL_GO: fu_go = 1'b1;
         S_WREN_GO: begin
            fu_go   = 1'b1;
            fu_kind = FK_WREN;
         end
         S_WORD_GO: begin
            fu_go   = 1'b1;
            fu_kind = first_q ? FK_AAI_FIRST : FK_AAI_NEXT;
         end
         S_WRDI_GO: begin
            fu_go   = 1'b1;
            fu_kind = FK_WRDI;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= S_IDLE;
         first_q      <= 1'b0;
         after_word_q <= 1'b0;
         err_o        <= 1'b0;
      end else begin
         unique case (st_q)
            S_IDLE: if (start_i) begin
               err_o <= 1'b0;
               st_q  <= S_SKIP;
            end
            S_SKIP: begin
               if (!cur_have) st_q <= S_FIN;
               else if (!word_erased) begin
                  after_word_q <= 1'b0;
                  st_q         <= S_POLL_GO;
               end
            end
            S_POLL_GO:   st_q <= S_POLL_WAIT;
            S_POLL_WAIT: if (fu_fin) begin
               if (st_busy) st_q <= S_POLL_GO;
               else if (after_word_q) begin
                  if (!st_ok) err_o <= 1'b1;
                  st_q <= S_ADV;
               end else st_q <= S_WREN_GO;
            end
            S_WREN_GO:   st_q <= S_WREN_WAIT;
            S_WREN_WAIT: if (fu_fin) begin
               first_q <= 1'b1;
               st_q    <= S_WORD_GO;
            end
            S_WORD_GO:   st_q <= S_WORD_WAIT;
            S_WORD_WAIT: if (fu_fin) begin
               after_word_q <= 1'b1;
               st_q         <= S_POLL_GO;
            end
            S_ADV: begin
               first_q <= 1'b0;
               st_q    <= S_EVAL;
            end
            S_EVAL: begin
               if (cur_have && !word_erased) st_q <= S_WORD_GO;
               else st_q <= S_WRDI_GO;
            end
            S_WRDI_GO:   st_q <= S_WRDI_WAIT;
            S_WRDI_WAIT: if (fu_fin) st_q <= S_SKIP;
            S_FIN:       st_q <= S_IDLE;
            default:     st_q <= S_IDLE;
         endcase
      end
   end

   assign busy_o = (st_q != S_IDLE);
   assign done_o = (st_q == S_FIN);

endmodule

// File: rtl/aai_word_programmer_chk.sv
module aai_word_programmer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       spi_sel_o,
   input logic       spi_req_o,
   input logic [7:0] spi_tx_o,
   input logic       spi_ack_i,
   input logic       busy_o,
   input logic       done_o,
   input logic       err_o
);
   AST_REQ_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      spi_req_o |-> spi_sel_o); // R9
   AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_req_o && !spi_ack_i) |=> (spi_req_o && $stable(spi_tx_o))); // R9
   AST_FRAME_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_sel_o) |=> !spi_sel_o); // R9
   AST_OPCODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sel_o) |-> (spi_tx_o == 8'h06 || spi_tx_o == 8'h04 ||
                            spi_tx_o == 8'h05 || spi_tx_o == 8'hAD)); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R10
   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !spi_sel_o); // R10
   AST_ERR_RISE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> busy_o); // R8
   AST_ERR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(err_o)); // R8
endmodule

bind aai_word_programmer aai_word_programmer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .spi_sel_o (spi_sel_o),
   .spi_req_o (spi_req_o),
   .spi_tx_o  (spi_tx_o),
   .spi_ack_i (spi_ack_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .err_o     (err_o)
);

// File: tb/aai_word_programmer_tb_top.sv
`timescale 1ns/1ps
module aai_word_programmer_tb_top;
   localparam int ADDR_W = 24;
   localparam int CNT_W  = 16;
   localparam int NVEC   = 10;

   // base[55:32] count[31:16] pattern[15:12] pre_busy[11:8] polls[7:4] inject[3:0]
   localparam logic [55:0] VEC [NVEC] = '{
      {24'h001000, 16'd16, 4'd0, 4'd0, 4'd0, 4'd0},
      {24'h0203FE, 16'd17, 4'd1, 4'd1, 4'd2, 4'd0},
      {24'h000000, 16'd12, 4'd2, 4'd1, 4'd1, 4'd0},
      {24'hFFFFF0, 16'd16, 4'd3, 4'd0, 4'd3, 4'd0},
      {24'h100000, 16'd10, 4'd4, 4'd2, 4'd1, 4'd0},
      {24'h000400, 16'd8,  4'd5, 4'd0, 4'd1, 4'd0},
      {24'h000800, 16'd1,  4'd0, 4'd0, 4'd0, 4'd0},
      {24'h000900, 16'd0,  4'd0, 4'd1, 4'd0, 4'd0},
      {24'h003000, 16'd6,  4'd0, 4'd0, 4'd1, 4'd1},
      {24'h003100, 16'd6,  4'd1, 4'd0, 4'd1, 4'd2}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [ADDR_W-1:0] base_addr_i = '0;
   logic [CNT_W-1:0]  byte_cnt_i = '0;
   logic [CNT_W-1:0]  buf_idx_o;
   logic [15:0]       buf_word_i;
   logic              spi_sel_o, spi_req_o;
   logic [7:0]        spi_tx_o;
   logic              spi_ack_i = 1'b0;
   logic [7:0]        spi_rx_i = 8'h00;
   logic              busy_o, done_o, err_o;

   logic [15:0] mem [128];
   assign buf_word_i = mem[buf_idx_o[6:0]];

   always #2.5 clk = ~clk;

   aai_word_programmer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
      .byte_cnt_i(byte_cnt_i), .buf_idx_o(buf_idx_o), .buf_word_i(buf_word_i),
      .spi_sel_o(spi_sel_o), .spi_req_o(spi_req_o), .spi_tx_o(spi_tx_o),
      .spi_ack_i(spi_ack_i), .spi_rx_i(spi_rx_i), .busy_o(busy_o),
      .done_o(done_o), .err_o(err_o)
   );

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   // flash model state
   int         busy_cnt, polls_cfg, inj_cfg, viol, pos, ngot, nexp;
   logic       wel, aai_on, prev_sel;
   logic [7:0] fb [8];
   logic [55:0] got_f [64];
   logic [55:0] exp_f [64];

   function automatic logic [7:0] status_byte();
      logic [3:0] bp = (inj_cfg == 1) ? 4'b0010 : 4'b0000;
      logic       w  = (inj_cfg == 2) ? 1'b0 : wel;
      return {1'b0, aai_on, bp, w, (busy_cnt != 0)};
   endfunction

   function automatic logic [15:0] pattern(int p, int i);
      case (p)
         0: return 16'h1200 + 16'(i);
         1: return (i % 3 == 2) ? 16'hFFFF : 16'hA500 + 16'(i);
         2: return 16'hFFFF;
         3: return (i < 2 || i > 5) ? 16'hFFFF : 16'h5A00 + 16'(i);
         4: return (i % 2 == 0) ? (16'hFF00 + 16'(i)) : (16'h00FF | 16'(i << 8));
         5: return (i % 4 == 3) ? 16'hFFFF : 16'h3300 + 16'(i);
         default: return 16'h0000;
      endcase
   endfunction

   initial begin : flash_model
      prev_sel = 1'b0;
      forever begin
         @(negedge clk);
         if (spi_sel_o && !prev_sel) begin
            pos = 0;
            for (int k = 0; k < 8; k++) fb[k] = 8'h00;
         end
         if (spi_req_o && !spi_sel_o) viol++;
         if (spi_ack_i) begin
            spi_ack_i = 1'b0;
         end else if (spi_sel_o && spi_req_o) begin
            if (pos < 8) fb[pos] = spi_tx_o;
            spi_rx_i  = (pos == 1 && fb[0] == 8'h05) ? status_byte() : 8'h00;
            spi_ack_i = 1'b1;
            pos++;
         end
         if (!spi_sel_o && prev_sel) begin
            if (fb[0] == 8'h05) begin
               if (busy_cnt > 0) busy_cnt--;
            end else begin
               if (busy_cnt > 0) viol++;
               if (fb[0] == 8'h06) wel = 1'b1;
               if (fb[0] == 8'h04) begin wel = 1'b0; aai_on = 1'b0; end
               if (fb[0] == 8'hAD) begin aai_on = 1'b1; busy_cnt = polls_cfg; end
               if (ngot < 64) got_f[ngot] = {8'(pos), fb[0], fb[1], fb[2], fb[3], fb[4], fb[5]};
               ngot++;
            end
         end
         prev_sel = spi_sel_o;
      end
   end

   task automatic push_exp(input logic [55:0] f);
      if (nexp < 64) exp_f[nexp] = f;
      nexp++;
   endtask

   task automatic build_expected(input logic [23:0] base, input int cnt, output bit any_word);
      int n = (cnt + 1) / 2;
      int i = 0;
      logic [23:0] a = base;
      nexp = 0;
      any_word = 1'b0;
      while (i < n) begin
         if (mem[i] == 16'hFFFF) begin i++; a += 24'd2; continue; end
         any_word = 1'b1;
         push_exp({8'd1, 8'h06, 40'h0});
         push_exp({8'd6, 8'hAD, a[23:16], a[15:8], a[7:0], mem[i][7:0], mem[i][15:8]});
         i++; a += 24'd2;
         while (i < n && mem[i] != 16'hFFFF) begin
            push_exp({8'd3, 8'hAD, mem[i][7:0], mem[i][15:8], 24'h0});
            i++; a += 24'd2;
         end
         push_exp({8'd1, 8'h04, 40'h0});
      end
   endtask

   task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic run_case(input logic [55:0] v);
      logic [23:0] base  = v[55:32];
      int          cnt   = int'(v[31:16]);
      int          pat   = int'(v[15:12]);
      int          pre   = int'(v[11:8]);
      int          inj   = int'(v[3:0]);
      bit          any_word;
      int          wait_cyc = 0;
      for (int i = 0; i < 128; i++) mem[i] = pattern(pat, i);
      build_expected(base, cnt, any_word);
      busy_cnt = pre; polls_cfg = int'(v[7:4]); inj_cfg = inj;
      viol = 0; ngot = 0; wel = 1'b0; aai_on = 1'b0;
      @(negedge clk);
      base_addr_i = base; byte_cnt_i = 16'(cnt); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o == 1'b1, "R10 busy after start", 64'(busy_o), 64'd1);
      check(err_o == 1'b0, "R8 err cleared by start", 64'(err_o), 64'd0);
      while (!done_o && wait_cyc < 20000) begin
         @(negedge clk);
         wait_cyc++;
      end
      check(done_o == 1'b1, "R10 done pulse", 64'(done_o), 64'd1);
      @(negedge clk);
      check(done_o == 1'b0 && busy_o == 1'b0, "R10 idle after done",
            64'({done_o, busy_o}), 64'd0);
      check(ngot == nexp, "R1 R2 R7 frame count", 64'(ngot), 64'(nexp));
      for (int k = 0; k < nexp && k < ngot && k < 64; k++)
         check(got_f[k] == exp_f[k], "R4 R5 R7 frame bytes", 64'(got_f[k]), 64'(exp_f[k]));
      check(viol == 0, "R3 R6 R9 frame while busy or req outside frame", 64'(viol), 64'd0);
      check(err_o == (inj != 0 && any_word), "R8 status check result",
            64'(err_o), 64'(inj != 0 && any_word));
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      repeat (4) @(negedge clk);
      // R11 reset state
      check({spi_sel_o, spi_req_o, busy_o, done_o, err_o} == 5'b0, "R11 reset outputs",
            64'({spi_sel_o, spi_req_o, busy_o, done_o, err_o}), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check({spi_sel_o, busy_o, err_o} == 3'b0, "R11 quiet after reset",
            64'({spi_sel_o, busy_o, err_o}), 64'd0);
      for (int r = 0; r < NVEC; r++) run_case(VEC[r]);
      // R8 error holds while idle until the next start
      repeat (3) @(negedge clk);
      check(err_o == 1'b1, "R8 err held while idle", 64'(err_o), 64'd1);
      // R8 a clean run after an error run clears err and reports none
      run_case({24'h004000, 16'd5, 4'd0, 4'd1, 4'd2, 4'd0});
      // R2 all-erased with an odd count: no frame at all
      run_case({24'h005001, 16'd9, 4'd2, 4'd0, 4'd0, 4'd0});
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule